// File: doc/BRIEF.md
# Serial Character Receiver with Flagged Receive Queue

This block turns an asynchronous serial line into characters. A strobe at sixteen times the bit rate paces it. The character length can be set from five to eight data bits. An optional parity position can be checked against even or odd parity, checked against a fixed level, skipped, or kept as an address marker. Each finished character enters a short queue together with three flags of its own: break, framing error and parity error.

A status byte reports on the queue. Its upper three bits are the error flags of the oldest queued character. In accumulate mode they are instead the sticky OR of the flags of every character since the last clear. Its lower five bits are live conditions: overrun, two transmitter conditions that pass through from outside, queue full, and character available. Two one-cycle command pulses act on the block. One clears the error state. The other empties the queue and restarts the receiver. The interrupt line follows either character available or queue full.

Top module: `uart_rx_stat`

## Requirements
- R1: `len_sel` sets the data bit count (0 gives 5 bits, 1 gives 6, 2 gives 7, 3 gives 8). Bits arrive least significant first. Data bits above the selected length read as zero on `rd_data`.
- R2: A falling edge starts a character only if the line is still low 8 strobes later. A shorter low pulse queues nothing.
- R3: With `par_mode` 0 the bit after the data is a parity bit. It should make the count of ones even (`par_odd`=0) or odd (`par_odd`=1). A mismatch sets the parity flag, which is `status[5]`.
- R4: With `par_mode` 1 the parity position must equal `par_odd`, and a mismatch sets `status[5]`. With `par_mode` 2 there is no parity position and `status[5]` stays 0.
- R5: With `par_mode` 3 the level received in the parity position is stored directly as the character's `status[5]` flag.
- R6: A stop bit sampled low sets the framing flag, which is `status[6]`.
- R7: A character whose every position, stop included, is low is a break. It queues one all-zero character with `status[7]`=1 and `status[6:5]`=0. Nothing more is queued until the line has returned high.
- R8: Characters leave the queue in arrival order, one per `rd_pop`. `status[0]` is 1 whenever a character is queued. `status[1]` is 1 once three are queued. A fourth is still held without loss.
- R9: A character that arrives while four are held replaces the newest one and sets `status[4]`. Only `cmd_err_reset` clears `status[4]`; `cmd_rx_reset` does not.
- R10: With `blk_err_mode`=0, `status[7:5]` shows the flags of the oldest queued character. They become 0 when the queue is empty.
- R11: With `blk_err_mode`=1, `status[7:5]` holds the OR of the flags of all characters received since the last clear. Reading characters does not clear it; `cmd_err_reset` or `cmd_rx_reset` does.
- R12: `cmd_rx_reset` empties the queue. The receiver then takes the next character normally.
- R13: `rx_irq` follows `status[0]` when `irq_full_sel`=0 and `status[1]` when `irq_full_sel`=1.
- R14: `status[3]` equals `tx_empty_in` and `status[2]` equals `tx_ready_in`, with no register delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| os_en | input | 1 | One-cycle strobe at 16x the bit rate |
| rx_line | input | 1 | Serial input, high when idle |
| len_sel | input | 2 | Data bit count select |
| par_mode | input | 2 | Parity handling select |
| par_odd | input | 1 | Parity sense or forced level |
| blk_err_mode | input | 1 | 1 selects accumulated error flags |
| irq_full_sel | input | 1 | 1 makes rx_irq follow queue full |
| cmd_err_reset | input | 1 | Pulse: clear overrun and accumulated flags |
| cmd_rx_reset | input | 1 | Pulse: empty queue, restart receiver |
| rd_pop | input | 1 | Pulse: remove the oldest character |
| tx_empty_in | input | 1 | Transmitter empty, shown in status[3] |
| tx_ready_in | input | 1 | Transmitter ready, shown in status[2] |
| rd_data | output | 8 | Oldest queued character, zero when empty |
| status | output | 8 | Status byte |
| rx_irq | output | 1 | Receiver interrupt |

## Verification
A character is queued at the middle-strobe of its stop bit. That is two clocks of line synchronisation plus one register after the strobe. The bench therefore reads results only after a further one and a half bit times of idle line, well after that point. Command pulses and `rd_pop` are driven on a falling edge and act at the next rising edge, so their effect is sampled one full clock later on the next falling edge. The pass-through bits and `rx_irq` select are combinational and are sampled 1 ns after the input changes.

// File: rtl/uart_rx_stat.sv
module uart_rx_stat #(
  parameter int DEPTH = 3,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          os_en,
  input  logic          rx_line,
  input  logic [1:0]    len_sel,
  input  logic [1:0]    par_mode,
  input  logic          par_odd,
  input  logic          blk_err_mode,
  input  logic          irq_full_sel,
  input  logic          cmd_err_reset,
  input  logic          cmd_rx_reset,
  input  logic          rd_pop,
  input  logic          tx_empty_in,
  input  logic          tx_ready_in,
  output logic [DW-1:0] rd_data,
  output logic [7:0]    status,
  output logic          rx_irq
);
  localparam int SLOTS = DEPTH + 1;
  localparam int PW    = $clog2(SLOTS);
  localparam int CW    = $clog2(SLOTS + 1);
  localparam int BW    = $clog2(DW);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP, S_BRK} st_t;

  st_t           st;
  logic [1:0]    sy;
  logic          line, line_prev, pbit;
  logic [3:0]    cnt;
  logic [BW-1:0] bitn, last_bit;
  logic [DW-1:0] sh;

  assign line     = sy[1];
  assign last_bit = BW'(4 + int'(len_sel));

  wire par_on = (par_mode != 2'b10);
  wire mid    = os_en && (cnt == 4'd15);

  logic pe_now;
  always_comb begin
    case (par_mode)
      2'b00:   pe_now = pbit != ((^sh) ^ par_odd);
      2'b01:   pe_now = pbit != par_odd;
      2'b11:   pe_now = pbit;
      default: pe_now = 1'b0;
    endcase
  end

  wire brk_now = !line && (sh == '0) && !(par_on && pbit);
  wire fe_now  = !line && !brk_now;
  wire push    = (st == S_STOP) && mid && !cmd_rx_reset;
  wire [DW+2:0] entry = {brk_now, fe_now, pe_now && !brk_now, sh};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sy <= 2'b11;
    else        sy <= {sy[0], rx_line};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; bitn <= '0; sh <= '0; pbit <= 1'b0; line_prev <= 1'b1;
    end else if (cmd_rx_reset) begin
      st <= S_IDLE;
    end else if (os_en) begin
      line_prev <= line;
      case (st)
        S_IDLE:
          if (line_prev && !line) begin st <= S_START; cnt <= '0; end
        S_START:
          if (cnt == 4'd7) begin
            cnt <= '0;
            if (!line) begin st <= S_DATA; bitn <= '0; sh <= '0; pbit <= 1'b0; end
            else st <= S_IDLE;
          end else cnt <= cnt + 4'd1;
        S_DATA: begin
          cnt <= cnt + 4'd1;
          if (cnt == 4'd15) begin
            sh[bitn] <= line;
            if (bitn == last_bit) st <= par_on ? S_PAR : S_STOP;
            else bitn <= bitn + 1'b1;
          end
        end
        S_PAR: begin
          cnt <= cnt + 4'd1;
          if (cnt == 4'd15) begin pbit <= line; st <= S_STOP; end
        end
        S_STOP: begin
          cnt <= cnt + 4'd1;
          if (cnt == 4'd15) st <= brk_now ? S_BRK : S_IDLE;
        end
        S_BRK:
          if (line) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(SLOTS - 1)) ? '0 : p + 1'b1;
  endfunction

  logic [DW+2:0] mem [SLOTS];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] fill;
  logic          ovr;
  logic [2:0]    acc;

  wire          pop     = rd_pop && (fill != '0);
  wire          ovf     = push && (fill == CW'(SLOTS)) && !pop;
  wire [PW-1:0] wp_last = (wp == '0) ? PW'(SLOTS - 1) : wp - 1'b1;

  always_ff @(posedge clk) begin
    if (push) mem[ovf ? wp_last : wp] <= entry;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; fill <= '0;
    end else if (cmd_rx_reset) begin
      wp <= '0; rp <= '0; fill <= '0;
    end else begin
      if (push && !ovf) wp <= nxt(wp);
      if (pop) rp <= nxt(rp);
      fill <= fill + CW'(push && !ovf) - CW'(pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             ovr <= 1'b0;
    else if (cmd_err_reset) ovr <= 1'b0;
    else if (ovf)           ovr <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             acc <= '0;
    else if (cmd_err_reset || cmd_rx_reset) acc <= '0;
    else if (push)                          acc <= acc | entry[DW+2:DW];
  end

  wire          have  = (fill != '0);
  wire          ffull = (fill >= CW'(DEPTH));
  wire [DW+2:0] head  = mem[rp];
  wire [2:0]    hflg  = have ? head[DW+2:DW] : 3'b000;

  assign rd_data = have ? head[DW-1:0] : '0;
  assign status  = {blk_err_mode ? acc : hflg, ovr, tx_empty_in, tx_ready_in, ffull, have};
  assign rx_irq  = irq_full_sel ? ffull : have;
endmodule

// File: rtl/uart_rx_stat_chk.sv
module uart_rx_stat_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] status,
  input logic       cmd_err_reset,
  input logic       cmd_rx_reset,
  input logic       blk_err_mode
);
  assert_full_has_data_R8: assert property (@(posedge clk) disable iff (!rst_n)
    status[1] |-> status[0]);

  assert_ovr_only_err_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status[4]) |-> $past(cmd_err_reset));

  assert_err_reset_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_err_reset |=> !status[4]);

  assert_rx_reset_empties_R12: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_rx_reset |=> (status[1:0] == 2'b00) && (status[7:5] == 3'b000));

  assert_block_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_err_mode && !cmd_err_reset && !cmd_rx_reset) |=>
      (!blk_err_mode || ((status[7:5] & $past(status[7:5])) == $past(status[7:5]))));
endmodule

bind uart_rx_stat uart_rx_stat_chk u_chk (
  .clk(clk), .rst_n(rst_n), .status(status),
  .cmd_err_reset(cmd_err_reset), .cmd_rx_reset(cmd_rx_reset),
  .blk_err_mode(blk_err_mode)
);

// File: tb/tb_uart_rx_stat.sv
module tb_uart_rx_stat;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic os_en = 1'b0;
  logic rx_line = 1'b1;
  logic [1:0] len_sel = 2'd3, par_mode = 2'd2;
  logic par_odd = 1'b0, blk_err_mode = 1'b0, irq_full_sel = 1'b0;
  logic cmd_err_reset = 1'b0, cmd_rx_reset = 1'b0, rd_pop = 1'b0;
  logic tx_empty_in = 1'b1, tx_ready_in = 1'b0;
  logic [7:0] rd_data, status;
  logic rx_irq;
  logic [1:0] div = 2'd0;
  int total = 0, bad = 0;

  uart_rx_stat dut (.*);

  always #2.5 clk = ~clk;

  always @(negedge clk) begin
    div = div + 2'd1;
    os_en = (div == 2'd0);
  end

  // {len, pmode, podd, pbit, stop, data, expected data, expected {brk,fe,pe}}
  localparam logic [25:0] VEC [13] = '{
    {2'd3, 2'd2, 1'b0, 1'b0, 1'b1, 8'hA5, 8'hA5, 3'b000},
    {2'd0, 2'd2, 1'b0, 1'b0, 1'b1, 8'h15, 8'h15, 3'b000},
    {2'd1, 2'd2, 1'b0, 1'b0, 1'b1, 8'h2A, 8'h2A, 3'b000},
    {2'd2, 2'd2, 1'b0, 1'b0, 1'b1, 8'hFF, 8'h7F, 3'b000},
    {2'd2, 2'd0, 1'b0, 1'b0, 1'b1, 8'h41, 8'h41, 3'b000},
    {2'd2, 2'd0, 1'b0, 1'b1, 1'b1, 8'h41, 8'h41, 3'b001},
    {2'd3, 2'd0, 1'b1, 1'b0, 1'b1, 8'h07, 8'h07, 3'b000},
    {2'd3, 2'd0, 1'b1, 1'b1, 1'b1, 8'h07, 8'h07, 3'b001},
    {2'd3, 2'd1, 1'b1, 1'b1, 1'b1, 8'h00, 8'h00, 3'b000},
    {2'd3, 2'd1, 1'b0, 1'b1, 1'b1, 8'h3C, 8'h3C, 3'b001},
    {2'd3, 2'd3, 1'b0, 1'b1, 1'b1, 8'h55, 8'h55, 3'b001},
    {2'd3, 2'd3, 1'b0, 1'b0, 1'b1, 8'h55, 8'h55, 3'b000},
    {2'd3, 2'd2, 1'b0, 1'b0, 1'b0, 8'h81, 8'h81, 3'b010}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    repeat (n * 4) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    rx_line = b;
    ticks(16);
  endtask

  task automatic frame(input logic [1:0] len, input logic [1:0] pm, input logic pb,
                       input logic [7:0] d, input logic stp);
    send_bit(1'b0);
    for (int i = 0; i < 5 + int'(len); i++) send_bit(d[i]);
    if (pm != 2'd2) send_bit(pb);
    send_bit(stp);
    rx_line = 1'b1;
    ticks(24);
  endtask

  task automatic pop();
    rd_pop = 1'b1; @(negedge clk); rd_pop = 1'b0;
  endtask

  task automatic err_rst();
    cmd_err_reset = 1'b1; @(negedge clk); cmd_err_reset = 1'b0;
  endtask

  task automatic rx_rst();
    cmd_rx_reset = 1'b1; @(negedge clk); cmd_rx_reset = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog R1 actual=timeout expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("reset status R10", status, 8'h08);
    chk("reset irq R13", rx_irq, 0);
    tx_empty_in = 1'b0; tx_ready_in = 1'b1; #1;
    chk("passthrough R14", status[3:2], 2'b01);
    tx_empty_in = 1'b1; tx_ready_in = 1'b0;
    @(negedge clk);

    for (int k = 0; k < 13; k++) begin
      logic [25:0] v;
      string tg;
      v = VEC[k];
      len_sel = v[25:24]; par_mode = v[23:22]; par_odd = v[21];
      tg = v[1] ? "R6" : (v[23:22] == 2'd0) ? "R3" : (v[23:22] == 2'd1) ? "R4" :
           (v[23:22] == 2'd3) ? "R5" : "R1";
      frame(v[25:24], v[23:22], v[20], v[18:11], v[19]);
      chk($sformatf("vec%0d data %s", k, tg), rd_data, v[10:3]);
      chk($sformatf("vec%0d flags %s", k, tg), status[7:5], v[2:0]);
      chk($sformatf("vec%0d ready R8", k), status[0], 1);
      pop();
      chk($sformatf("vec%0d drained R8", k), status[0], 0);
    end
    len_sel = 2'd3; par_mode = 2'd2; par_odd = 1'b0;

    // R2: short low pulse rejected
    rx_line = 1'b0; ticks(4); rx_line = 1'b1; ticks(200);
    chk("glitch ignored R2", status[0], 0);

    // R7: break
    rx_line = 1'b0; ticks(16 * 13); rx_line = 1'b1; ticks(24);
    chk("break count R7", status[1:0], 2'b01);
    chk("break data R7", rd_data, 8'h00);
    chk("break flags R7", status[7:5], 3'b100);
    pop();
    chk("break single R7", status[0], 0);

    // R8, R13, R9: fill and overrun
    irq_full_sel = 1'b1;
    frame(2'd3, 2'd2, 1'b0, 8'h11, 1'b1);
    frame(2'd3, 2'd2, 1'b0, 8'h22, 1'b1);
    chk("two held R8", status[1:0], 2'b01);
    chk("irq full sel R13", rx_irq, 0);
    irq_full_sel = 1'b0; #1;
    chk("irq ready sel R13", rx_irq, 1);
    frame(2'd3, 2'd2, 1'b0, 8'h33, 1'b1);
    chk("three full R8", status[1:0], 2'b11);
    irq_full_sel = 1'b1; #1;
    chk("irq on full R13", rx_irq, 1);
    frame(2'd3, 2'd2, 1'b0, 8'h44, 1'b1);
    chk("fourth no overrun R8", status[4], 0);
    frame(2'd3, 2'd2, 1'b0, 8'h55, 1'b1);
    chk("overrun set R9", status[4], 1);
    chk("order 1 R8", rd_data, 8'h11); pop();
    chk("order 2 R8", rd_data, 8'h22); pop();
    chk("order 3 R8", rd_data, 8'h33); pop();
    chk("replaced newest R9", rd_data, 8'h55); pop();
    chk("empty after four R8", status[0], 0);
    rx_rst();
    chk("overrun survives rx reset R9", status[4], 1);
    err_rst();
    chk("overrun cleared R9", status[4], 0);
    irq_full_sel = 1'b0;

    // R12: receiver reset
    frame(2'd3, 2'd2, 1'b0, 8'h66, 1'b1);
    frame(2'd3, 2'd2, 1'b0, 8'h77, 1'b1);
    rx_rst();
    chk("rx reset empties R12", status[1:0], 2'b00);
    frame(2'd3, 2'd2, 1'b0, 8'h5A, 1'b1);
    chk("after rx reset R12", rd_data, 8'h5A);
    pop();

    // R10: per-character flags
    par_mode = 2'd0; par_odd = 1'b0;
    frame(2'd3, 2'd0, 1'b0, 8'h01, 1'b1);
    frame(2'd3, 2'd0, 1'b0, 8'h03, 1'b1);
    chk("head flags R10", status[7:5], 3'b001);
    pop();
    chk("next head flags R10", status[7:5], 3'b000);
    pop();

    // R11: accumulated flags
    blk_err_mode = 1'b1;
    frame(2'd3, 2'd0, 1'b0, 8'h01, 1'b1);
    frame(2'd3, 2'd0, 1'b0, 8'h03, 1'b1);
    pop(); pop();
    chk("sticky after reads R11", status[7:5], 3'b001);
    chk("queue empty R11", status[0], 0);
    err_rst();
    chk("err reset clears R11", status[7:5], 3'b000);
    frame(2'd3, 2'd0, 1'b0, 8'h01, 1'b1);
    chk("sticky again R11", status[7:5], 3'b001);
    rx_rst();
    chk("rx reset clears R11", status[7:5], 3'b000);
    blk_err_mode = 1'b0;

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule